// File: doc/BRIEF.md
# Linked-Descriptor Burst DMA Channel

This block is one DMA channel that reads packet data from system memory and hands it, word by word, to a USB endpoint FIFO port. Software prepares a chain of three-word descriptors in memory. It then loads the address of the first descriptor and pulses `start`. The channel reads each descriptor in turn, copies its words into its current-descriptor registers, and streams the referenced buffer. Buffer addresses rise by one word on every beat. The channel follows the next pointer until it meets a null pointer, or a descriptor that does not ask for a reload.

The buffer is moved in bursts. Each burst is as long as the smallest of three values: the programmed endpoint size, the words still left in the buffer, and a cap for the endpoint type (128 words for bulk, 256 for isochronous). When the descriptor asks for it, the bus lock is held from the first burst of a buffer to its last, so no other master can break into the buffer. The memory side uses a per-beat valid/ready handshake, and read data is returned in the same cycle as `ready`.

Top module: `dma_chain_channel`

## Requirements
- R1: After `start`, the channel reads the descriptor at addresses P, P+4 and P+8, in that order. The three words are loaded into `cur_next`, `cur_addr` and `cur_ctrl`.
- R2: Control word fields, starting at bit 0: bit 0 enable, bit 1 reload-next, bit 2 buffer interrupt enable, bit 3 bus lock, bit 4 endpoint type (0 bulk, 1 isochronous), bits 20:5 buffer length in bytes.
- R3: A buffer of L bytes takes ceil(L/4) data beats. The beats go to consecutive word addresses, starting at the buffer address. Each accepted beat raises `fifo_push`, and `fifo_data` carries the read word.
- R4: Every burst length, shown on `burst_len`, is min(endpoint size, remaining words, cap). The cap is 128 for bulk and 256 for isochronous. An endpoint size of 0 counts as the cap. The last burst of a buffer may be shorter.
- R5: With the lock bit set, `bus_lock` stays high from the first data beat of a buffer to its last. It is low during descriptor reads and for buffers that do not request the lock.
- R6: The next descriptor is fetched only when reload-next is set and the next pointer is non-zero. Otherwise `chain_done` pulses and `busy` falls.
- R7: `buf_done` pulses for one cycle after every buffer. `buf_irq` pulses with it only when the interrupt enable bit is set.
- R8: A descriptor with enable clear, or with zero length, makes no data beats but still gives `buf_done`.
- R9: While `bus_valid` is high and `bus_ready` is low, the address and the beat count hold, and no data beat is lost.
- R10: A `start` pulse while `busy` is high is ignored.
- R11: Reset leaves the channel idle: `busy`, `bus_valid`, `bus_lock`, `buf_done` and `chain_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that starts a chain |
| desc_head | input | ADDR_W | Byte address of the first descriptor |
| ep_words | input | EP_W | Programmed endpoint size in words |
| bus_valid | output | 1 | Read request valid |
| bus_addr | output | ADDR_W | Read byte address |
| bus_lock | output | 1 | Bus lock for the buffer in progress |
| bus_ready | input | 1 | Beat accepted; read data valid |
| bus_rdata | input | 32 | Read data |
| fifo_push | output | 1 | Data word to endpoint FIFO |
| fifo_data | output | 32 | Word pushed to FIFO |
| burst_len | output | CNT_W | Length of the current burst |
| busy | output | 1 | Chain in progress |
| buf_done | output | 1 | Buffer finished pulse |
| buf_irq | output | 1 | Buffer interrupt pulse |
| chain_done | output | 1 | Chain finished pulse |
| cur_next | output | ADDR_W | Current next-descriptor pointer |
| cur_addr | output | ADDR_W | Current buffer address |
| cur_ctrl | output | 32 | Current control word |

## Verification
A data beat and its `fifo_push` fall in the same cycle that `bus_ready` meets `bus_valid`. The first data beat comes two cycles after the third descriptor word, and there is one setup cycle between bursts. `buf_done` rises the cycle after the last beat, and `chain_done` shares that cycle for the final buffer. A monitor samples every output on the falling edge and tallies beats, addresses, burst lengths, lock gaps and pulses. The checks compare those tallies only after `chain_done` has been seen and two more cycles have passed, so no result is read before it is due.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;

    localparam int WORD_W = 32;
    localparam int LEN_W  = 16;

    // Control word: enable in bit 0 upward, length in bits 20:5
    typedef struct packed {
        logic [10:0]      spare;
        logic [LEN_W-1:0] len_bytes;
        logic             iso;
        logic             lock;
        logic             irq_en;
        logic             reload;
        logic             enable;
    } ctrl_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_BSET,
        ST_DATA,
        ST_BUFEND
    } state_e;

endpackage

// File: rtl/dmac_len_words.sv
module dmac_len_words #(
    parameter int LEN_W   = 16,
    parameter int WORDS_W = LEN_W - 1
) (
    input  logic [LEN_W-1:0]   bytes_in,
    output logic [WORDS_W-1:0] words_out
);
    // Round a byte count up to whole words
    always_comb begin
        words_out = WORDS_W'(bytes_in >> 2) + WORDS_W'(|bytes_in[1:0]);
    end
endmodule

// File: rtl/dmac_burst_sizer.sv
module dmac_burst_sizer #(
    parameter int WORDS_W  = 15,
    parameter int EP_W     = 11,
    parameter int CNT_W    = 9,
    parameter int BULK_CAP = 128,
    parameter int ISO_CAP  = 256
) (
    input  logic [WORDS_W-1:0] remain,
    input  logic [EP_W-1:0]    ep_size,
    input  logic               iso,
    output logic [CNT_W-1:0]   burst
);
    logic [31:0] cap_v;
    logic [31:0] lim_v;

    always_comb begin
        cap_v = iso ? 32'(ISO_CAP) : 32'(BULK_CAP);
        lim_v = cap_v;
        if (ep_size != '0 && 32'(ep_size) < lim_v) lim_v = 32'(ep_size);
        if (32'(remain) < lim_v) lim_v = 32'(remain);
        burst = CNT_W'(lim_v);
    end

    always_comb begin
        if (remain != '0) begin
            p_burst_nonzero_r4: assert (burst != '0);
        end
    end
endmodule

// File: rtl/dma_chain_channel.sv
module dma_chain_channel
    import dma_chain_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int EP_W     = 11,
    parameter int BULK_CAP = 128,
    parameter int ISO_CAP  = 256,
    localparam int WORDS_W = LEN_W - 1,
    localparam int CNT_W   = $clog2(ISO_CAP + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] desc_head,
    input  logic [EP_W-1:0]   ep_words,
    output logic              bus_valid,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_lock,
    input  logic              bus_ready,
    input  logic [WORD_W-1:0] bus_rdata,
    output logic              fifo_push,
    output logic [WORD_W-1:0] fifo_data,
    output logic [CNT_W-1:0]  burst_len,
    output logic              busy,
    output logic              buf_done,
    output logic              buf_irq,
    output logic              chain_done,
    output logic [ADDR_W-1:0] cur_next,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [WORD_W-1:0] cur_ctrl
);

    typedef struct packed {
        state_e              st;
        logic [1:0]          idx;
        logic [ADDR_W-1:0]   ptr;
        logic [ADDR_W-1:0]   nxt;
        logic [ADDR_W-1:0]   addr;
        ctrl_t               ctrl;
        logic [WORDS_W-1:0]  remain;
        logic [CNT_W-1:0]    left;
        logic [CNT_W-1:0]    blen;
    } regs_t;

    regs_t q, d;

    ctrl_t              fetched_ctrl;
    logic [WORDS_W-1:0] fetched_words;
    logic [CNT_W-1:0]   sized_burst;
    logic               follow;

    assign fetched_ctrl = ctrl_t'(bus_rdata);

    dmac_len_words #(
        .LEN_W   (LEN_W),
        .WORDS_W (WORDS_W)
    ) u_len (
        .bytes_in  (fetched_ctrl.len_bytes),
        .words_out (fetched_words)
    );

    dmac_burst_sizer #(
        .WORDS_W  (WORDS_W),
        .EP_W     (EP_W),
        .CNT_W    (CNT_W),
        .BULK_CAP (BULK_CAP),
        .ISO_CAP  (ISO_CAP)
    ) u_sizer (
        .remain  (q.remain),
        .ep_size (ep_words),
        .iso     (q.ctrl.iso),
        .burst   (sized_burst)
    );

    assign follow = q.ctrl.reload && (q.nxt != '0);

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.ptr = desc_head;
                    d.idx = 2'd0;
                    d.st  = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (bus_ready) begin
                    d.idx = q.idx + 2'd1;
                    case (q.idx)
                        2'd0:    d.nxt  = bus_rdata;
                        2'd1:    d.addr = bus_rdata;
                        default: begin
                            d.ctrl   = fetched_ctrl;
                            d.remain = fetched_words;
                            if (!fetched_ctrl.enable || fetched_words == '0)
                                d.st = ST_BUFEND;
                            else
                                d.st = ST_BSET;
                        end
                    endcase
                end
            end
            ST_BSET: begin
                d.blen = sized_burst;
                d.left = sized_burst;
                d.st   = ST_DATA;
            end
            ST_DATA: begin
                if (bus_ready) begin
                    d.addr   = q.addr + ADDR_W'(4);
                    d.remain = q.remain - WORDS_W'(1);
                    d.left   = q.left - CNT_W'(1);
                    if (q.remain == WORDS_W'(1))
                        d.st = ST_BUFEND;
                    else if (q.left == CNT_W'(1))
                        d.st = ST_BSET;
                end
            end
            ST_BUFEND: begin
                if (follow) begin
                    d.ptr = q.nxt;
                    d.idx = 2'd0;
                    d.st  = ST_FETCH;
                end else begin
                    d.st = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, idx: 2'd0, ptr: '0, nxt: '0, addr: '0,
                   ctrl: '0, remain: '0, left: '0, blen: '0};
        end else begin
            q <= d;
        end
    end

    assign bus_valid  = (q.st == ST_FETCH) || (q.st == ST_DATA);
    assign bus_addr   = (q.st == ST_FETCH) ? q.ptr + ADDR_W'({q.idx, 2'b00}) : q.addr;
    assign bus_lock   = q.ctrl.lock && ((q.st == ST_BSET) || (q.st == ST_DATA));
    assign fifo_push  = (q.st == ST_DATA) && bus_ready;
    assign fifo_data  = bus_rdata;
    assign burst_len  = q.blen;
    assign busy       = (q.st != ST_IDLE);
    assign buf_done   = (q.st == ST_BUFEND);
    assign buf_irq    = (q.st == ST_BUFEND) && q.ctrl.irq_en;
    assign chain_done = (q.st == ST_BUFEND) && !follow;
    assign cur_next   = q.nxt;
    assign cur_addr   = q.addr;
    assign cur_ctrl   = q.ctrl;

    // Stalled beat keeps request and address
    p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr)));

    // Consecutive beats in a burst step one word
    p_seq_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_DATA && bus_ready && q.left > CNT_W'(1))
        |=> (bus_addr == $past(bus_addr) + ADDR_W'(4)));

    // Burst never exceeds the cap of its endpoint type
    p_burst_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_DATA) |->
        (32'(q.blen) <= (q.ctrl.iso ? ISO_CAP : BULK_CAP)));

    // Lock survives the gap between bursts of one buffer
    p_lock_between_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_push && q.ctrl.lock && q.remain > WORDS_W'(1)) |=> bus_lock);

    // Descriptor reads never locked
    p_fetch_unlocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_FETCH) |-> !bus_lock);

    // End of chain is always also end of a buffer
    p_chain_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        chain_done |-> buf_done);

    // Buffer-done is a single-cycle pulse
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        buf_done |=> !buf_done);

    // Idle channel stays off the bus
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!bus_valid && !bus_lock));

endmodule

// File: tb/dma_chain_channel_test.sv
module dma_chain_channel_test;
    import dma_chain_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] desc_head = '0;
    logic [10:0] ep_words = 11'd4;
    logic        bus_ready = 1'b1;
    logic [31:0] bus_rdata;
    logic        bus_valid, bus_lock, fifo_push, busy, buf_done, buf_irq, chain_done;
    logic [31:0] bus_addr, fifo_data, cur_next, cur_addr, cur_ctrl;
    logic [8:0]  burst_len;

    always #5 clk = ~clk;

    logic [31:0] mem [0:1023];
    assign bus_rdata = mem[bus_addr[11:2]];

    dma_chain_channel uut (
        .clk(clk), .rst_n(rst_n), .start(start), .desc_head(desc_head),
        .ep_words(ep_words), .bus_valid(bus_valid), .bus_addr(bus_addr),
        .bus_lock(bus_lock), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
        .fifo_push(fifo_push), .fifo_data(fifo_data), .burst_len(burst_len),
        .busy(busy), .buf_done(buf_done), .buf_irq(buf_irq),
        .chain_done(chain_done), .cur_next(cur_next), .cur_addr(cur_addr),
        .cur_ctrl(cur_ctrl)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit stall_mode = 1'b0;
    int cyc = 0;

    // monitor tallies
    int beats, data_err, nb, burst_rem, nf, fetch_locked, lock_gap, lock_hi;
    int n_bd, n_cd, n_irq, bi, k;
    bit in_buf;
    int bursts [0:7];
    logic [31:0] fetch_log [0:15];
    logic [31:0] exp_buf [0:3];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    function automatic logic [31:0] mk(bit en, bit nx, bit irq, bit lk, bit iso, int len);
        return {11'b0, 16'(len), iso, lk, irq, nx, en};
    endfunction

    task automatic clear_logs();
        beats = 0; data_err = 0; nb = 0; burst_rem = 0; nf = 0;
        fetch_locked = 0; lock_gap = 0; lock_hi = 0;
        n_bd = 0; n_cd = 0; n_irq = 0; bi = 0; k = 0; in_buf = 1'b0;
    endtask

    task automatic run_chain(input logic [31:0] head);
        @(posedge clk); #1;
        clear_logs();
        desc_head = head;
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        for (int t = 0; t < 20000 && n_cd == 0; t++) @(posedge clk);
        repeat (2) @(posedge clk);
        #2;
    endtask

    // ready pattern driver
    initial forever begin
        @(posedge clk); #1;
        cyc = cyc + 1;
        bus_ready = stall_mode ? (cyc % 3 != 0) : 1'b1;
    end

    // falling-edge monitor
    initial forever begin
        @(negedge clk);
        if (in_buf && !buf_done && !bus_lock) lock_gap++;
        if (bus_lock) lock_hi++;
        if (bus_valid && bus_ready && !fifo_push) begin
            if (bus_lock) fetch_locked++;
            if (nf < 16) fetch_log[nf] = bus_addr;
            nf++;
        end
        if (fifo_push) begin
            logic [31:0] e;
            e = exp_buf[bi] + 32'(4 * k);
            if (bus_addr !== e || fifo_data !== mem[e[11:2]]) data_err++;
            k++;
            beats++;
            if (burst_rem == 0) begin
                if (nb < 8) bursts[nb] = int'(burst_len);
                nb++;
                burst_rem = int'(burst_len);
            end
            burst_rem--;
            in_buf = 1'b1;
        end
        if (buf_done) begin
            n_bd++;
            if (buf_irq) n_irq++;
            in_buf = 1'b0;
            k = 0;
            burst_rem = 0;
            if (bi < 3) bi++;
        end
        if (chain_done) n_cd++;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // single-descriptor vectors: endpoint size, type, length, lock -> expected results
    localparam int NV = 5;
    localparam int V_EP    [NV] = '{4, 8, 300, 300, 3};
    localparam int V_ISO   [NV] = '{0, 0, 0, 1, 1};
    localparam int V_LEN   [NV] = '{32, 22, 1200, 1200, 4};
    localparam int V_LOCK  [NV] = '{1, 0, 1, 1, 0};
    localparam int V_BEATS [NV] = '{8, 6, 300, 300, 1};
    localparam int V_NB    [NV] = '{2, 1, 3, 2, 1};
    localparam int V_FIRST [NV] = '{4, 6, 128, 256, 1};
    localparam int V_LAST  [NV] = '{4, 6, 44, 44, 1};

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 32'hD000_0000 + 32'(i);
        clear_logs();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R11 busy after reset", 32'(busy), 0);
        chk("R11 bus_valid after reset", 32'(bus_valid), 0);
        chk("R11 bus_lock after reset", 32'(bus_lock), 0);
        chk("R11 done pulses after reset", 32'({buf_done, chain_done}), 0);

        // R3 R4 R5 table walk
        for (int i = 0; i < NV; i++) begin
            mem[0] = 32'h0;
            mem[1] = 32'h400;
            mem[2] = mk(1, 1, 0, V_LOCK[i] != 0, V_ISO[i] != 0, V_LEN[i]);
            exp_buf[0] = 32'h400;
            ep_words = 11'(V_EP[i]);
            stall_mode = (i % 2) == 1;
            run_chain(32'h0);
            chk("R3 beat count", 32'(beats), 32'(V_BEATS[i]));
            chk("R3 address and data sequence errors", 32'(data_err), 0);
            chk("R4 burst count", 32'(nb), 32'(V_NB[i]));
            chk("R4 first burst length", 32'(bursts[0]), 32'(V_FIRST[i]));
            chk("R4 last burst length", 32'(bursts[(nb > 0 ? nb - 1 : 0) % 8]), 32'(V_LAST[i]));
            if (V_LOCK[i] != 0) chk("R5 lock gaps inside buffer", 32'(lock_gap), 0);
            else                chk("R5 lock unused when not requested", 32'(lock_hi), 0);
            chk("R5 fetch beats locked", 32'(fetch_locked), 0);
            chk("R7 buf_done count", 32'(n_bd), 1);
            chk("R6 busy cleared", 32'(busy), 0);
        end

        // R1 R6 R7 R9 R10: three-descriptor chain, stalls, start while busy
        mem[0]  = 32'h10; mem[1]  = 32'h400; mem[2]  = mk(1, 1, 1, 1, 0, 40);
        mem[4]  = 32'h20; mem[5]  = 32'h800; mem[6]  = mk(1, 1, 0, 0, 1, 13);
        mem[8]  = 32'h0;  mem[9]  = 32'hC00; mem[10] = mk(1, 1, 1, 0, 0, 8);
        mem[64] = 32'h0;  mem[65] = 32'h200; mem[66] = mk(1, 1, 0, 0, 0, 4);
        exp_buf[0] = 32'h400; exp_buf[1] = 32'h800; exp_buf[2] = 32'hC00; exp_buf[3] = 32'h0;
        ep_words = 11'd4;
        stall_mode = 1'b1;
        fork
            run_chain(32'h0);
            begin
                repeat (25) @(posedge clk);
                #1 desc_head = 32'h100;
                start = 1'b1;
                @(posedge clk); #1 start = 1'b0;
            end
        join
        chk("R1 descriptor read count", 32'(nf), 9);
        chk("R1 first descriptor word addr", fetch_log[0], 32'h0);
        chk("R1 third word of second descriptor", fetch_log[5], 32'h18);
        chk("R1 last descriptor read addr", fetch_log[8], 32'h28);
        chk("R1 cur_next loaded", cur_next, 32'h0);
        chk("R1 cur_ctrl loaded", cur_ctrl, mk(1, 1, 1, 0, 0, 8));
        chk("R3 cur_addr after last beat", cur_addr, 32'hC08);
        chk("R9 chain beats under stalls", 32'(beats), 16);
        chk("R9 chain data errors under stalls", 32'(data_err), 0);
        chk("R4 chain burst count", 32'(nb), 5);
        chk("R4 short tail burst", 32'(bursts[2]), 2);
        chk("R7 buf_done per buffer", 32'(n_bd), 3);
        chk("R7 buf_irq only when enabled", 32'(n_irq), 2);
        chk("R6 chain_done once", 32'(n_cd), 1);
        chk("R10 start while busy ignored", 32'(n_bd + nf), 12);
        chk("R5 fetch never locked in chain", 32'(fetch_locked), 0);

        // R6: reload clear stops despite non-null next
        stall_mode = 1'b0;
        mem[0] = 32'h10; mem[1] = 32'h400; mem[2] = mk(1, 0, 0, 0, 0, 8);
        exp_buf[0] = 32'h400;
        run_chain(32'h0);
        chk("R6 reload clear reads one descriptor", 32'(nf), 3);
        chk("R6 reload clear one buffer", 32'(n_bd), 1);
        chk("R6 reload clear chain_done", 32'(n_cd), 1);
        chk("R2 length 8 bytes gives 2 beats", 32'(beats), 2);

        // R8: enable clear, then zero length
        mem[0] = 32'h0; mem[2] = mk(0, 1, 1, 0, 0, 16);
        run_chain(32'h0);
        chk("R8 disabled buffer has no beats", 32'(beats), 0);
        chk("R8 disabled buffer still done", 32'(n_bd), 1);
        chk("R7 irq on disabled buffer", 32'(n_irq), 1);
        mem[2] = mk(1, 1, 0, 0, 0, 0);
        run_chain(32'h0);
        chk("R8 zero length has no beats", 32'(beats), 0);
        chk("R8 zero length still done", 32'(n_bd), 1);
        chk("R6 idle after zero length", 32'(busy), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule